// File: doc/BRIEF.md
# SPI master with slave-select management

This block is a byte-wide SPI port that operates only as a bus master and sits on the internal 8-bit peripheral bus of a small controller. Software programs a control register (enable, master, clock polarity, clock phase, rate) and a configuration/status register (where the slave-select level comes from, plus three flags). It then starts a transfer by writing a byte to the data register. The block drives SCK and MOSI, samples MISO, shifts eight bits MSB first, and leaves the received byte in a read buffer.

The internal slave-select level comes from one of two places: the external active-low select pin, or a software bit when a source bit selects software control. Master mode and enable stay set only while that internal level is high. If it drops, hardware clears both bits, stops any shift in progress and records a mode fault. A write to the data register while a byte is still shifting leaves that transfer alone and raises a write-collision flag. Each flag clears through a short access sequence that starts with a read of the status register.

Top module: `spim_top`

## Requirements
- R1: Address 0 is the data register, address 1 the control register (bit0 enable, bit1 master, bit2 clock polarity, bit3 clock phase, bits 6:4 rate code, bit7 reads 0), and address 2 the configuration/status register (bit0 software select level, bit1 select source, bit5 mode fault, bit6 write collision, bit7 transfer complete, other bits read 0). Every register and flag resets to 0.
- R2: Each SCK half period lasts 2 << code bus clocks for rate codes 0 to 5, which gives an SCK period of 4, 8, 16, 32, 64 or 128 bus clocks. Codes 6 and 7 give a half period of 64 bus clocks.
- R3: Whenever no transfer is in progress, SCK sits at the level of the clock polarity bit.
- R4: A transfer exchanges 8 bits MSB first over 16 SCK edges. With clock phase 0, MOSI is valid before the first edge and both sides sample on the leading edges. With clock phase 1, data changes on the leading edges and is sampled on the trailing edges. The received byte reads back from address 0.
- R5: A data-register write starts a transfer only when enable and master are both set and the internal select is high. Otherwise the write produces no SCK edges and no transfer-complete flag.
- R6: The internal select equals status bit0 when status bit1 is 1, and the select pin level when status bit1 is 0.
- R7: While the internal select is low, enable and master read 0 from the next cycle on and any transfer in progress is abandoned. If either bit was set, the mode-fault flag is raised.
- R8: Until the configuration/status register has been written once after reset, control-register writes leave the master bit at 0.
- R9: A data-register write during a transfer does not change the bytes exchanged, and it sets the write-collision flag.
- R10: Transfer complete is set when the eighth bit finishes. A status read followed by any data-register access clears it; a data-register access that has no status read before it leaves it set.
- R11: Write collision is cleared by a status read followed by a data-register read.
- R12: Mode fault is cleared by a status read followed by a control-register write; a control write with no status read before it leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| ssel_n_pin | input | 1 | External active-low slave select, synchronous to clk |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bound assertions check the following on every cycle: SCK holds its idle level outside a transfer, a low internal select removes enable and master and raises the fault flag, a master write made before any configuration write leaves the master bit clear, a collision write raises its flag, the end of a shift raises transfer complete, and no transfer begins while the port is disabled. Only the bench scenarios can show the rest: that the bytes exchanged with a modelled slave are correct in all four clock modes, that the edge spacing matches each rate code, that a collision leaves the shift intact, and that each flag clears only after its full access sequence and not after part of it.

// File: rtl/spim_pkg.sv
// spim_pkg: shared register addresses, configuration type and the rate
// decode used by the SPI master. Assumes an 8-bit bus with 2 address bits.
package spim_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_STAT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic       en;
        logic       mst;
        logic       cpol;
        logic       cpha;
        logic [2:0] rate;
    } spim_cfg_t;

    // SCK half period in bus clocks for a rate code; codes above 5 saturate.
    function automatic logic [6:0] half_period(input logic [2:0] code);
        half_period = (code > 3'd5) ? 7'd64 : (7'd2 << code);
    endfunction

endpackage

// File: rtl/spim_baudgen.sv
// spim_baudgen: produces one tick per SCK half period while a transfer runs.
// Assumes the rate code stays constant during a transfer. The counter restarts
// from zero whenever run is low, so the first tick comes a full half period
// after the transfer starts.
module spim_baudgen #(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] rate,
    output logic       tick
);
    import spim_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(half_period(rate) - 7'd1);
    assign tick  = run && (cnt == limit);

    // Count bus clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spim_shifter.sv
// spim_shifter: moves one DW-bit word MSB first over 2*DW SCK edges. Even edge
// numbers are leading edges and odd ones trailing. Phase 0 samples on leading
// and shifts on trailing; phase 1 drives on leading and samples on trailing.
// Assumes start arrives only while idle and that polarity and phase are held
// during a transfer. abort clears the transfer at once.
module spim_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [DW-1:0] tx_byte,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          sck,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx_byte
);
    localparam int EDGES = 2 * DW;
    localparam int EW    = $clog2(EDGES);

    logic [DW-1:0] sh;
    logic [EW-1:0] ecnt;
    logic          phase;
    logic          rx_bit;
    logic          mosi_q;
    logic          last;

    assign last    = tick && (ecnt == EW'(EDGES - 1));
    assign done    = last && busy;
    assign sck     = cpol ^ phase;
    assign mosi    = mosi_q;
    assign rx_byte = cpha ? {sh[DW-2:0], miso} : {sh[DW-2:0], rx_bit};

    // Advance the shift state on each half-period tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            sh     <= '0;
            ecnt   <= '0;
            phase  <= 1'b0;
            rx_bit <= 1'b0;
            mosi_q <= 1'b0;
        end else if (abort) begin
            busy  <= 1'b0;
            ecnt  <= '0;
            phase <= 1'b0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            sh     <= tx_byte;
            ecnt   <= '0;
            phase  <= 1'b0;
            mosi_q <= tx_byte[DW-1];
        end else if (tick && busy) begin
            phase <= ~phase;
            ecnt  <= ecnt + 1'b1;
            if (!ecnt[0]) begin
                if (!cpha) rx_bit <= miso;
                else       mosi_q <= sh[DW-1];
            end else begin
                if (!cpha) begin
                    sh     <= {sh[DW-2:0], rx_bit};
                    mosi_q <= sh[DW-2];
                end else begin
                    sh <= {sh[DW-2:0], miso};
                end
            end
            if (last) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/spim_regs.sv
// spim_regs: register file, slave-select source choice, mode-fault handling
// and flag clearing sequences. Assumes one-cycle bus strobes, never a read and
// a write in the same cycle, and a select pin already synchronous to clk.
module spim_regs #(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic                ssel_n_pin,
    input  logic                busy,
    input  logic                done,
    input  logic [DW-1:0]       rx_byte,
    output spim_pkg::spim_cfg_t cfg,
    output logic                sel_n,
    output logic                start,
    output logic [DW-1:0]       tx_byte,
    output logic                cfg_seen,
    output logic                wcol,
    output logic                tc,
    output logic                mflt,
    output logic                wr_data,
    output logic                wr_ctrl
);
    import spim_pkg::*;

    logic          wr_stat, rd_stat, rd_data;
    logic          ssi_q, ssm_q, armed_q;
    logic [DW-1:0] rxbuf_q;

    assign wr_data = bus_wr && (bus_addr == REG_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
    assign wr_stat = bus_wr && (bus_addr == REG_STAT);
    assign rd_data = bus_rd && (bus_addr == REG_DATA);
    assign rd_stat = bus_rd && (bus_addr == REG_STAT);

    assign sel_n   = ssm_q ? ssi_q : ssel_n_pin;
    assign start   = wr_data && cfg.en && cfg.mst && sel_n && !busy;
    assign tx_byte = bus_wdata;

    // Control fields; a low internal select overrides enable and master.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.en   <= bus_wdata[0];
                if (cfg_seen) cfg.mst <= bus_wdata[1];
                cfg.cpol <= bus_wdata[2];
                cfg.cpha <= bus_wdata[3];
                cfg.rate <= bus_wdata[6:4];
            end
            if (!sel_n) begin
                cfg.en  <= 1'b0;
                cfg.mst <= 1'b0;
            end
        end
    end

    // Select source bits and the first-configuration-write marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssi_q    <= 1'b0;
            ssm_q    <= 1'b0;
            cfg_seen <= 1'b0;
        end else if (wr_stat) begin
            ssi_q    <= bus_wdata[0];
            ssm_q    <= bus_wdata[1];
            cfg_seen <= 1'b1;
        end
    end

    // Remember a status read until the next data or control access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (rd_stat) begin
            armed_q <= 1'b1;
        end else if (wr_data || rd_data || wr_ctrl) begin
            armed_q <= 1'b0;
        end
    end

    // Status flags: setting wins over clearing in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc   <= 1'b0;
            wcol <= 1'b0;
            mflt <= 1'b0;
        end else begin
            if (done)                                tc <= 1'b1;
            else if (armed_q && (wr_data || rd_data)) tc <= 1'b0;
            if (wr_data && busy)        wcol <= 1'b1;
            else if (armed_q && rd_data) wcol <= 1'b0;
            if (!sel_n && (cfg.en || cfg.mst)) mflt <= 1'b1;
            else if (armed_q && wr_ctrl)       mflt <= 1'b0;
        end
    end

    // Capture the received word at the end of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    rxbuf_q <= '0;
        else if (done) rxbuf_q <= rx_byte;
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            REG_DATA: bus_rdata = rxbuf_q;
            REG_CTRL: bus_rdata = DW'({1'b0, cfg.rate, cfg.cpha, cfg.cpol, cfg.mst, cfg.en});
            REG_STAT: bus_rdata = DW'({tc, wcol, mflt, 3'b000, ssm_q, ssi_q});
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_top.sv
// spim_top: SPI master port. Connects the register file, the half-period
// tick generator and the shifter. A transfer is abandoned as soon as enable
// or master is clear. Assumes a synchronous select pin and one-cycle strobes.
module spim_top #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ssel_n_pin,
    output logic          spi_sck,
    output logic          spi_mosi,
    input  logic          spi_miso
);
    import spim_pkg::*;

    localparam int CNT_W = $clog2(64) + 1;

    spim_cfg_t     cfg;
    logic          sel_n, start, busy, done, tick, abort;
    logic          cfg_seen, wcol, tc, mflt, wr_data, wr_ctrl;
    logic [DW-1:0] tx_byte, rx_byte;

    assign abort = !(cfg.en && cfg.mst);

    spim_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ssel_n_pin(ssel_n_pin), .busy(busy), .done(done), .rx_byte(rx_byte),
        .cfg(cfg), .sel_n(sel_n), .start(start), .tx_byte(tx_byte),
        .cfg_seen(cfg_seen), .wcol(wcol), .tc(tc), .mflt(mflt),
        .wr_data(wr_data), .wr_ctrl(wr_ctrl)
    );

    spim_baudgen #(.CNT_W(CNT_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .rate(cfg.rate), .tick(tick)
    );

    spim_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .tx_byte(tx_byte), .cpol(cfg.cpol), .cpha(cfg.cpha), .tick(tick),
        .miso(spi_miso), .busy(busy), .sck(spi_sck), .mosi(spi_mosi),
        .done(done), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/spim_checker.sv
// spim_checker: cycle-level properties of the SPI master, bound to spim_top.
module spim_checker (
    input logic clk,
    input logic rst_n,
    input logic sel_n,
    input logic en,
    input logic mst,
    input logic cpol,
    input logic sck,
    input logic busy,
    input logic done,
    input logic wr_data,
    input logic wr_ctrl,
    input logic cfg_seen,
    input logic wcol,
    input logic tc,
    input logic mflt
);
    // R7: a low internal select removes enable and master.
    a_r7_sel_low_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |=> (!en && !mst));

    // R7: losing select while configured raises the fault flag.
    a_r7_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && (en || mst)) |=> mflt);

    // R3: SCK idles at the polarity level.
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol));

    // R8: master write before any configuration write is dropped.
    a_r8_mst_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !cfg_seen) |=> !mst);

    // R9: data write during a shift raises the collision flag.
    a_r9_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && busy) |=> wcol);

    // R10: end of the eighth bit raises transfer complete.
    a_r10_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> tc);

    // R5: no transfer begins while the port is not enabled as master.
    a_r5_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(en && mst)) |=> !busy);
endmodule

bind spim_top spim_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .en(cfg.en), .mst(cfg.mst),
    .cpol(cfg.cpol), .sck(spi_sck), .busy(busy), .done(done),
    .wr_data(wr_data), .wr_ctrl(wr_ctrl), .cfg_seen(cfg_seen),
    .wcol(wcol), .tc(tc), .mflt(mflt)
);

// File: tb/spim_top_tb_top.sv
// Bench for spim_top: a slave model on the SPI pins, directed corner cases
// and seeded random transfers.
module spim_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ss_pin = 1'b1;
    logic       sck, mosi;
    logic       miso = 1'b0;
    int         n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    spim_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .ssel_n_pin(ss_pin),
        .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso)
    );

    // Slave model state (written only by the model process).
    logic [7:0] ld_tx = 8'h00;
    logic       ld_cpol = 1'b0, ld_cpha = 1'b0;
    int         ld_seq = 0, ld_seen = 0;
    logic [7:0] s_tx = 8'h00, s_rx = 8'h00;
    logic       s_cpol = 1'b0, s_cpha = 1'b0, s_prev = 1'b0, lead;
    int         s_edges = 0, s_gap = 0, s_last = 0, cyc = 0;

    always @(negedge clk) begin
        cyc++;
        if (ld_seq != ld_seen) begin
            ld_seen = ld_seq;
            s_tx = ld_tx; s_rx = 8'h00; s_edges = 0; s_gap = 0;
            s_cpol = ld_cpol; s_cpha = ld_cpha; miso = ld_tx[7];
        end else if (sck !== s_prev) begin
            lead = (s_prev == s_cpol);
            if (s_edges == 1) s_gap = cyc - s_last;
            s_last = cyc;
            s_edges++;
            if (lead) begin
                if (!s_cpha) s_rx = {s_rx[6:0], mosi};
                else begin miso = s_tx[7]; s_tx = {s_tx[6:0], 1'b0}; end
            end else begin
                if (s_cpha) s_rx = {s_rx[6:0], mosi};
                else begin s_tx = {s_tx[6:0], 1'b0}; miso = s_tx[7]; end
            end
        end
        s_prev = sck;
    end

    function automatic int exp_half(input logic [2:0] code);
        return (code > 3'd5) ? 64 : (2 << code);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic slave_load(input logic [7:0] t, input logic p, input logic h);
        ld_tx = t; ld_cpol = p; ld_cpha = h; ld_seq++;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic wait_done(input string tag);
        logic [7:0] d;
        bit seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            bus_read(2'd2, d);
            seen = d[7];
        end
        chk(tag, 32'(seen), 32'd1);
    endtask

    task automatic do_xfer(input logic [7:0] tx, input logic [7:0] stx,
                           input logic p, input logic h, input logic [2:0] rate);
        logic [7:0] d;
        bus_write(2'd1, {1'b0, rate, h, p, 2'b11});
        slave_load(stx, p, h);
        bus_write(2'd0, tx);
        wait_done("R10 complete");
        bus_read(2'd0, d);
        chk("R4 received byte", 32'(d), 32'(stx));
        chk("R4 byte seen by slave", 32'(s_rx), 32'(tx));
        chk("R4 edge count", 32'(s_edges), 32'd16);
        chk("R2 half period", 32'(s_gap), 32'(exp_half(rate)));
        chk("R3 idle level", 32'(sck), 32'(p));
        bus_read(2'd2, d);
        chk("R10 cleared after status then data", 32'(d[7]), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, d); chk("R1 data reset", 32'(d), 32'h00);
        bus_read(2'd1, d); chk("R1 ctrl reset", 32'(d), 32'h00);
        bus_read(2'd2, d); chk("R1 status reset", 32'(d), 32'h00);
        chk("R3 reset idle", 32'(sck), 32'd0);

        // R8 master bit ignored before configuration write
        bus_write(2'd1, 8'h03);
        bus_read(2'd1, d); chk("R8 master gated", 32'(d), 32'h01);

        // R5 no transfer while not master
        slave_load(8'h00, 1'b0, 1'b0);
        bus_write(2'd0, 8'h5A);
        repeat (60) @(negedge clk);
        chk("R5 no edges", 32'(s_edges), 32'd0);
        bus_read(2'd2, d); chk("R5 no complete", 32'(d), 32'h00);

        // R8 master accepted after configuration write (software select high)
        bus_write(2'd2, 8'h03);
        bus_write(2'd1, 8'h03);
        bus_read(2'd1, d); chk("R8 master accepted", 32'(d), 32'h03);

        // Directed: four modes at fastest rate, and slow codes
        for (int m = 0; m < 4; m++)
            do_xfer(8'hA5 ^ 8'(m), 8'h3C + 8'(m), m[0], m[1], 3'd0);
        do_xfer(8'h80, 8'h01, 1'b1, 1'b0, 3'd5);
        do_xfer(8'h7E, 8'hE7, 1'b0, 1'b1, 3'd6);
        do_xfer(8'h01, 8'hFF, 1'b1, 1'b1, 3'd7);

        // R9 / R11 write collision
        bus_write(2'd1, 8'h3B);
        slave_load(8'h3C, 1'b0, 1'b1);
        bus_write(2'd0, 8'hA5);
        repeat (40) @(negedge clk);
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, d);
        bus_read(2'd2, d); chk("R9 collision flag", 32'(d[6]), 32'd1);
        chk("R11 kept without status read", 32'(d[6]), 32'd1);
        wait_done("R9 complete");
        bus_read(2'd0, d); chk("R9 received undisturbed", 32'(d), 32'h3C);
        chk("R9 sent undisturbed", 32'(s_rx), 32'hA5);
        chk("R9 edge count", 32'(s_edges), 32'd16);
        bus_read(2'd2, d); chk("R11 collision cleared", 32'(d[6]), 32'd0);

        // R10 data access without a prior status read keeps complete
        bus_write(2'd1, 8'h03);
        slave_load(8'h81, 1'b0, 1'b0);
        bus_write(2'd0, 8'h18);
        repeat (80) @(negedge clk);
        bus_read(2'd0, d); chk("R4 received byte", 32'(d), 32'h81);
        bus_read(2'd2, d); chk("R10 kept without status read", 32'(d[7]), 32'd1);
        bus_read(2'd0, d);
        bus_read(2'd2, d); chk("R10 cleared", 32'(d[7]), 32'd0);

        // R6 software select high: pin ignored
        ss_pin = 1'b0;
        repeat (10) @(negedge clk);
        bus_read(2'd1, d); chk("R6 pin ignored ctrl", 32'(d), 32'h03);
        bus_read(2'd2, d); chk("R6 pin ignored status", 32'(d), 32'h03);
        ss_pin = 1'b1;

        // R7 software select low
        bus_write(2'd2, 8'h02);
        bus_read(2'd1, d); chk("R7 enable and master dropped", 32'(d), 32'h00);
        bus_read(2'd2, d); chk("R7 fault raised", 32'(d), 32'h22);

        // R12 fault clearing sequence
        bus_write(2'd2, 8'h03);
        bus_read(2'd0, d);
        bus_write(2'd1, 8'h03);
        bus_read(2'd2, d); chk("R12 kept without status read", 32'(d[5]), 32'd1);
        bus_read(2'd1, d); chk("R12 ctrl rewritten", 32'(d), 32'h03);
        bus_write(2'd1, 8'h03);
        bus_read(2'd2, d); chk("R12 fault cleared", 32'(d), 32'h03);

        // R6 / R7 pin select low mid-transfer
        bus_write(2'd2, 8'h00);
        bus_write(2'd1, 8'h47);
        slave_load(8'h00, 1'b1, 1'b0);
        bus_write(2'd0, 8'hC3);
        repeat (100) @(negedge clk);
        ss_pin = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 abort idle level", 32'(sck), 32'd1);
        bus_read(2'd1, d); chk("R7 pin fault ctrl", 32'(d), 32'h44);
        repeat (600) @(negedge clk);
        bus_read(2'd2, d); chk("R6 pin fault status no complete", 32'(d), 32'h20);
        ss_pin = 1'b1;
        repeat (2) @(negedge clk);

        // Random transfers
        for (int i = 0; i < 16; i++) begin
            logic [7:0] t, s;
            logic [2:0] r;
            logic p, h;
            t = 8'($urandom); s = 8'($urandom);
            r = 3'($urandom_range(7, 0));
            p = 1'($urandom); h = 1'($urandom);
            do_xfer(t, s, p, h, r);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule